// File: doc/BRIEF.md
# RTC INT1 Interrupt Waveform Generator

This block produces the INT1 pin waveform of a real-time clock. A 4-bit mode field selects the waveform. The choices are off, a copy of a selected-frequency square wave, a per-minute event that stays latched, two per-minute pulses of different length, an alarm-1 latch, or the raw 32 kHz enable stream on the pin. The timekeeping logic supplies the 32 kHz enable, the one-per-second tick with its seconds count and the alarm-1 match strobe. A prescaler supplies the selected-frequency wave.

The pin is active-low and registered, so every response shows one clock after the inputs that cause it. A single-cycle flag-set pulse tells the status register that INT1 has fired. A status read releases the latched modes. Writing a new mode value cancels any pulse or latch in progress.

Top module: `rtc_int1_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, int1_n is 1 and int1_flag_set is 0.
- R2: With int1_mode = 0000, int1_n stays 1 whatever the other inputs do.
- R3: With int1_mode[3]=0 and int1_mode[1:0]=01 (bit 2 ignored), int1_n equals the inverse of freq_wave from one cycle earlier.
- R4: With int1_mode[3]=0 and int1_mode[1:0]=10, a minute event (sec_tick high with sec_count = 0) drives int1_n to 0 on the next cycle. int1_n stays 0 until a cycle with status_rd high and no minute event. A minute event and a read in the same cycle leave int1_n at 0.
- R5: With int1_mode = 0011, a minute event starts an active phase that lasts exactly STEADY_SECS (default 30) sec_tick pulses, counting from the minute event itself.
- R6: With int1_mode = 0100, alarm1_hit drives int1_n to 0 on the next cycle. A status read clears it, and a hit in the same cycle as a read wins.
- R7: With int1_mode = 0111, a minute event starts an active phase that ends after SHORT_TICKS (default 259) tick_32k enables.
- R8: With int1_mode[3]=1, int1_n equals the inverse of tick_32k from one cycle earlier, and int1_flag_set stays 0.
- R9: In every mode except 1xxx, int1_flag_set is high for exactly one cycle, in the cycle where int1_n first goes from 1 to 0.
- R10: In the cycle after int1_mode takes a new value, int1_n is 1 and int1_flag_set is 0. Any latch or pulse that was in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int1_mode | input | 4 | INT1 waveform select field |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| sec_tick | input | 1 | One-cycle pulse once per second |
| sec_count | input | SEC_W | Seconds value, valid with sec_tick |
| alarm1_hit | input | 1 | Alarm-1 match strobe |
| freq_wave | input | 1 | Selected-frequency square wave |
| status_rd | input | 1 | Status register read strobe |
| int1_n | output | 1 | INT1 pin level, active low |
| int1_flag_set | output | 1 | One-cycle pulse when INT1 activates |

## Verification
Every internal state fault reaches int1_n within one clock. A stuck or cleared latch shows as a wrong pin level on the cycle after the minute event, alarm or read that should have moved it. A counter that loads the wrong value, or decrements on the wrong enable, shows as a low phase that ends early or late. The reference model catches this on the exact cycle of release. A stale mode register, or a mode-change clear that does not happen, shows one cycle after the new mode is written.

// File: rtl/rtc_int1_pkg.sv
// Shared types for the INT1 waveform generator.
// Assumes: the mode field is 4 bits wide; bit 3 selects the clock passthrough.
package rtc_int1_pkg;

    typedef enum logic [2:0] {
        K_OFF,
        K_FREQ,
        K_EDGE,
        K_STEADY,
        K_ALARM,
        K_SHORT,
        K_CLK32
    } int1_kind_e;

    // Map the raw 4-bit field onto one waveform kind
    function automatic int1_kind_e decode_kind(input logic [3:0] m);
        int1_kind_e k;
        if (m[3]) begin
            k = K_CLK32;
        end else begin
            case (m[2:0])
                3'b001, 3'b101: k = K_FREQ;
                3'b010, 3'b110: k = K_EDGE;
                3'b011:         k = K_STEADY;
                3'b100:         k = K_ALARM;
                3'b111:         k = K_SHORT;
                default:        k = K_OFF;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/int1_mode_dec.sv
// Mode decoder: classifies the current field and flags a change against
// the value held in the previous cycle.
// Assumes: mode_prev is the registered copy of mode kept by the parent.
module int1_mode_dec
    import rtc_int1_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [3:0] mode_prev,
    output int1_kind_e kind,
    output logic       changed
);

    // Combinational classification and change detection
    always_comb begin
        kind    = decode_kind(mode);
        changed = (mode != mode_prev);
    end

endmodule

// File: rtl/int1_event_latch.sv
// Sticky event latch: set by an event, released by a status read.
// Assumes: clr (mode change) has highest priority, then set, then read.
module int1_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic rd,
    output logic q,
    output logic q_next
);

    // Next-state priority: clear, set, read release, hold
    always_comb begin
        if (clr)       q_next = 1'b0;
        else if (set)  q_next = 1'b1;
        else if (rd)   q_next = 1'b0;
        else           q_next = q;
    end

    // Hold the latched event
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr && !rd) |=> q);                              // R4
    AST_LATCH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> q);                                   // R6

endmodule

// File: rtl/int1_span_counter.sv
// Down-counter that defines an active span: loads LOAD on start,
// counts down on each dec enable, and is active while non-zero.
// Assumes: load and dec may coincide; load wins.
module int1_span_counter #(
    parameter int LOAD = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic dec,
    output logic busy_next
);

    localparam int CW = $clog2(LOAD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_d;

    // Next count: clear, reload, step down, hold
    always_comb begin
        if (clr)                      cnt_d = '0;
        else if (load)                cnt_d = CW'(LOAD);
        else if (dec && cnt != '0)    cnt_d = cnt - 1'b1;
        else                          cnt_d = cnt;
        busy_next = (cnt_d != '0);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    AST_SPAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LOAD));                                      // R5
    AST_SPAN_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !dec) |=> $stable(cnt));              // R7

endmodule

// File: rtl/rtc_int1_gen.sv
// INT1 waveform generator. Selects the pin waveform from the 4-bit mode,
// times the per-minute pulses, latches edge and alarm events, and passes
// the 32 kHz enable through. Pin and flag are registered.
// Assumes: tick_32k, sec_tick and alarm1_hit are one-cycle pulses in clk;
// a minute starts on sec_tick with sec_count = 0.
module rtc_int1_gen
    import rtc_int1_pkg::*;
#(
    parameter int SEC_W       = 6,
    parameter int STEADY_SECS = 30,
    parameter int SHORT_TICKS = 259
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       int1_mode,
    input  logic             tick_32k,
    input  logic             sec_tick,
    input  logic [SEC_W-1:0] sec_count,
    input  logic             alarm1_hit,
    input  logic             freq_wave,
    input  logic             status_rd,
    output logic             int1_n,
    output logic             int1_flag_set
);

    logic [3:0] mode_q;
    int1_kind_e kind;
    logic       changed;
    logic       minute_evt;
    logic       latch_set;
    logic       latch_q;
    logic       latch_nx;
    logic       steady_busy;
    logic       short_busy;
    logic       act_next;
    logic       flag_d;

    int1_mode_dec u_dec (
        .mode      (int1_mode),
        .mode_prev (mode_q),
        .kind      (kind),
        .changed   (changed)
    );

    // Minute boundary and latch set source per mode
    always_comb begin
        minute_evt = sec_tick && (sec_count == '0);
        latch_set  = !changed && (((kind == K_EDGE) && minute_evt) ||
                                  ((kind == K_ALARM) && alarm1_hit));
    end

    int1_event_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (changed),
        .set    (latch_set),
        .rd     (status_rd),
        .q      (latch_q),
        .q_next (latch_nx)
    );

    int1_span_counter #(.LOAD(STEADY_SECS)) u_steady (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (changed),
        .load      (!changed && (kind == K_STEADY) && minute_evt),
        .dec       (sec_tick),
        .busy_next (steady_busy)
    );

    int1_span_counter #(.LOAD(SHORT_TICKS)) u_short (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (changed),
        .load      (!changed && (kind == K_SHORT) && minute_evt),
        .dec       (tick_32k),
        .busy_next (short_busy)
    );

    // Select the active level for the next cycle and the activation flag
    always_comb begin
        act_next = 1'b0;
        if (!changed) begin
            case (kind)
                K_FREQ:   act_next = freq_wave;
                K_EDGE,
                K_ALARM:  act_next = latch_nx;
                K_STEADY: act_next = steady_busy;
                K_SHORT:  act_next = short_busy;
                K_CLK32:  act_next = tick_32k;
                default:  act_next = 1'b0;
            endcase
        end
        flag_d = act_next && int1_n && (kind != K_CLK32);
    end

    // Output and mode history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q        <= 4'b0000;
            int1_n        <= 1'b1;
            int1_flag_set <= 1'b0;
        end else begin
            mode_q        <= int1_mode;
            int1_n        <= !act_next;
            int1_flag_set <= flag_d;
        end
    end

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_mode == 4'b0000) |=> int1_n);                     // R2
    AST_CHANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_mode != mode_q) |=> (int1_n && !int1_flag_set));  // R10
    AST_FLAG_WITH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        int1_flag_set |-> !int1_n);                             // R9
    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int1_flag_set |=> !int1_flag_set);                      // R9
    AST_CLK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_mode[3] && (int1_mode == mode_q)) |=> (int1_n == !$past(tick_32k))); // R8
    AST_CLK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        int1_mode[3] |=> !int1_flag_set);                       // R8
    AST_LATCH_NOT_IN_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_mode[3] && (int1_mode == mode_q)) |-> !latch_q);  // R10

endmodule

// File: tb/sim_rtc_int1_gen.sv
module sim_rtc_int1_gen;

    localparam int SEC_W   = 6;
    localparam int STEADY  = 30;
    localparam int SHORTT  = 259;
    localparam int SEC_DIV = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       int1_mode = 4'b0000;
    logic             tick_32k = 1'b0;
    logic             sec_tick = 1'b0;
    logic [SEC_W-1:0] sec_count = '0;
    logic             alarm1_hit = 1'b0;
    logic             freq_wave = 1'b0;
    logic             status_rd = 1'b0;
    logic             int1_n;
    logic             int1_flag_set;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sec_ph = 0;
    int secs = 0;
    bit want_alarm = 0;
    bit want_read = 0;
    bit read_at_minute = 0;

    // reference model state
    int m_latch = 0, m_steady = 0, m_short = 0;
    logic [3:0] m_mode = 4'b0000;
    bit exp_n = 1, exp_flag = 0, last_chg = 0;

    always #10 clk = ~clk;

    rtc_int1_gen #(.SEC_W(SEC_W), .STEADY_SECS(STEADY), .SHORT_TICKS(SHORTT)) u0 (
        .clk(clk), .rst_n(rst_n), .int1_mode(int1_mode), .tick_32k(tick_32k),
        .sec_tick(sec_tick), .sec_count(sec_count), .alarm1_hit(alarm1_hit),
        .freq_wave(freq_wave), .status_rd(status_rd), .int1_n(int1_n),
        .int1_flag_set(int1_flag_set));

    function automatic string mode_tag(input logic [3:0] m);
        if (m[3]) return "R8";
        case (m[2:0])
            3'b001, 3'b101: return "R3";
            3'b010, 3'b110: return "R4";
            3'b011:         return "R5";
            3'b100:         return "R6";
            3'b111:         return "R7";
            default:        return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // behavioural next state from the inputs of this cycle
    task automatic model_step();
        bit chg, minute, act;
        chg = (int1_mode != m_mode);
        minute = sec_tick && (sec_count == 0);
        act = 0;
        if (chg) begin
            m_latch = 0; m_steady = 0; m_short = 0;
        end else if (int1_mode[3]) begin
            act = tick_32k;
        end else begin
            case (int1_mode[2:0])
                3'b001, 3'b101: act = freq_wave;
                3'b010, 3'b110: begin
                    if (minute) m_latch = 1; else if (status_rd) m_latch = 0;
                    act = (m_latch != 0);
                end
                3'b100: begin
                    if (alarm1_hit) m_latch = 1; else if (status_rd) m_latch = 0;
                    act = (m_latch != 0);
                end
                3'b011: begin
                    if (minute) m_steady = STEADY;
                    else if (sec_tick && m_steady > 0) m_steady--;
                    act = (m_steady > 0);
                end
                3'b111: begin
                    if (minute) m_short = SHORTT;
                    else if (tick_32k && m_short > 0) m_short--;
                    act = (m_short > 0);
                end
                default: act = 0;
            endcase
        end
        exp_flag = !chg && !int1_mode[3] && act && exp_n;
        exp_n = !act;
        last_chg = chg;
        m_mode = int1_mode;
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            cyc++;
            sec_ph = (sec_ph + 1) % SEC_DIV;
            sec_tick = (sec_ph == 0);
            if (sec_tick) begin
                secs = (secs + 1) % 60;
                sec_count = SEC_W'(secs);
            end
            tick_32k = (cyc % 2 == 0);
            freq_wave = ((cyc / 6) % 2 == 1);
            alarm1_hit = want_alarm; want_alarm = 0;
            status_rd = want_read; want_read = 0;
            if (read_at_minute && sec_tick && secs == 0) begin
                status_rd = 1; read_at_minute = 0;
            end
            @(posedge clk);
            model_step();
            @(negedge clk);
            if (last_chg) begin
                check("R10", int1_n, exp_n);
            end else begin
                check(mode_tag(int1_mode), int1_n, exp_n);
            end
            check("R9", int1_flag_set, exp_flag);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        int1_mode = m;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired at cycle %0d: got hung expected done", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lows;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int1_n, 1'b1);
        check("R1", int1_flag_set, 1'b0);
        rst_n = 1'b1;
        run(1);
        check("R1", int1_n, 1'b1);

        // R2: off mode ignores all events
        want_alarm = 1; run(2); want_read = 1; run(40);

        // R3: selected-frequency modes, bit 2 ignored
        set_mode(4'b0001); run(40);
        set_mode(4'b0101); run(40);

        // R4: per-minute latch, read release, read at minute keeps it
        set_mode(4'b0010); run(1000);
        want_read = 1; run(20);
        read_at_minute = 1; run(1000);
        want_read = 1; run(10);
        set_mode(4'b0110); run(1000);

        // R5: 30 second steady pulse
        set_mode(4'b0011); run(1100);
        lows = 0;
        for (int i = 0; i < 960; i++) begin
            run(1);
            if (!int1_n) lows++;
        end
        // R5: one minute holds STEADY seconds of active phase
        check("R5", (lows == STEADY * SEC_DIV), 1'b1);

        // R6: alarm latch, read, hit and read together
        set_mode(4'b0100); run(5);
        want_alarm = 1; run(10);
        want_read = 1; run(5);
        want_alarm = 1; want_read = 1; run(5);
        check("R6", int1_n, 1'b0);
        want_read = 1; run(3);
        check("R6", int1_n, 1'b1);

        // R10: mode change drops a held alarm latch
        want_alarm = 1; run(3);
        set_mode(4'b0110); run(5);
        check("R10", int1_n, 1'b1);

        // R7: short per-minute pulse
        set_mode(4'b0111); run(1000);
        lows = 0;
        for (int i = 0; i < 960; i++) begin
            run(1);
            if (!int1_n) lows++;
        end
        // R7: tick_32k every 2 cycles, so SHORT ticks span about 2*SHORT cycles
        check("R7", (lows >= 2 * SHORTT - 2 && lows <= 2 * SHORTT + 2), 1'b1);

        // R8: clock passthrough modes
        set_mode(4'b1000); run(40);
        set_mode(4'b1101); want_alarm = 1; run(40);

        // R10: switch away mid short pulse
        set_mode(4'b0111); run(1000);
        set_mode(4'b0000); run(10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule